// File: doc/BRIEF.md
# Bitplane Pixel Colour Combiner

This block forms one palette index per pixel from a set of bitplane bytes. All plane bytes are captured together on a load strobe. Each plane then feeds one bit per pixel, starting with the most significant bit of its byte. Plane n drives bit n of the index. A per-plane enable mask and a per-plane complement mask decide whether a plane passes its data, passes its data inverted, or supplies a fixed 0 or 1. Setting complement bits on unused planes therefore picks a sub-range of the palette.

Two mode bits change which planes take part. In the narrow-plane (640-pixel) mode the upper half of the planes supply no data. In the 1280-pixel mode the top index bit is replaced by the half-pixel phase, so the second half of every pixel reads the palette 128 entries higher than the first half. When cell attributes are on, plane 3 stops supplying colour. The upper nibble of its byte is captured as underline, reverse and blink flags for the current cell, and these flags act on plane 2. Plane 2 is also the foreground plane used for sprite priority and collision, and its final contribution is brought out as a separate flag.

Top module: `bpc_pixel_combiner`

## Requirements
- R1: After reset all plane data and the latched cell attributes are zero, so every index bit equals either 0 or its complement bit.
- R2: A load captures every plane byte at once. The first pixel takes bit 7 of each byte, and each pixel enable moves on to the next lower bit. A load in the same cycle as a pixel enable wins.
- R3: A plane whose enable bit is clear drives its index bit with its complement bit, whatever its data.
- R4: An enabled plane drives its index bit with its current data bit XOR its complement bit. Plane n always drives index bit n.
- R5: With the narrow-plane mode set, planes 4 to 7 behave as disabled, whatever their enable bits.
- R6: With the 1280 mode set, index bit 7 equals the half-pixel phase input. The lower seven bits do not depend on the phase.
- R7: With attributes on, bits 7 (underline), 5 (reverse) and 4 (blink) of the plane 3 byte are captured at each load. They hold for every pixel of that byte. Bit 6 (highlight) has no effect.
- R8: Underline forces the plane 2 data bit to 1 while the last-row input is high.
- R9: Reverse inverts the plane 2 data bit, and this includes a forced underline bit.
- R10: Blink has no effect while the blink phase is low. While it is high, a cell with reverse or underline shows plain data, and a cell with neither shows plane 2 data as 0.
- R11: With attributes on, index bit 3 equals the plane 3 complement bit, whatever the plane 3 data or enable bit.
- R12: The foreground flag equals the plane 2 contribution to the index, after attributes, enable and complement are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Captures all plane bytes and the cell attributes |
| pix_en | input | 1 | Moves on to the next pixel of the loaded bytes |
| plane_data | input | PLANES*PIX_PER_BYTE | Plane bytes, plane n in bits [8n+7:8n] |
| plane_enable | input | PLANES | Per-plane enable mask |
| plane_comp | input | PLANES | Per-plane complement mask |
| attr_en | input | 1 | Plane 3 carries cell attributes applied to plane 2 |
| mode_640 | input | 1 | Narrow-plane mode, upper half of planes unused |
| mode_1280 | input | 1 | Top index bit replaced by half-pixel phase |
| half_phase | input | 1 | Low in the first half of a pixel, high in the second half |
| blink_phase | input | 1 | Blink off-phase indication |
| cell_row_last | input | 1 | Current raster line is the last row of the cell |
| pal_index | output | PLANES | Palette index of the current pixel |
| fg_flag | output | 1 | Foreground bit taken from plane 2 |

## Verification
The hardest case to reach is the interaction of attributes that sit in another plane's byte with the mode and mask settings. The blink-hide and reverse-of-underline cases only show up when one load carries a particular plane 3 nibble, particular plane 2 data and a particular row and phase together. The stimulus goes through all sixteen upper-nibble values of the plane 3 byte, one per load. At every pixel position of each load it cycles through all 64 combinations of the six mode and phase inputs, under several enable and complement mask pairs. The bench model forms each index bit from the loaded bytes.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

   // Cell attribute flags captured from the attribute plane byte
   typedef struct packed {
      logic underline;
      logic reverse;
      logic blink;
   } cell_attr_t;

   // Positions of the flags inside the attribute byte (counted from its msb)
   localparam int unsigned UL_FROM_TOP  = 0;
   localparam int unsigned REV_FROM_TOP = 2;
   localparam int unsigned BLK_FROM_TOP = 3;

endpackage

// File: rtl/bpc_plane_shifter.sv
module bpc_plane_shifter #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             shift,
   input  logic [WIDTH-1:0] din,
   output logic             pix
);
   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH-1:0] sr_q;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bpc_plane_shifter: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load) begin
         sr_q <= din;
      end else if (shift) begin
         sr_q <= {sr_q[MSB-1:0], 1'b0};
      end
   end

   assign pix = sr_q[MSB];

   // R2: a pixel step without a load moves the next bit to the output
   a_r2_shift_step : assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !load) |=> (pix == $past(sr_q[MSB-1])));

   // R2: a load presents the byte msb on the next cycle
   a_r2_load_msb : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (pix == $past(din[MSB])));

endmodule

// File: rtl/bpc_attr_latch.sv
module bpc_attr_latch
   import bpc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  cell_attr_t attr_in,
   output cell_attr_t attr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         attr_q <= '0;
      end else if (load) begin
         attr_q <= attr_in;
      end
   end

   // R7: attributes stay fixed between loads
   a_r7_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(attr_q));

endmodule

// File: rtl/bpc_attr_apply.sv
module bpc_attr_apply
   import bpc_pkg::*;
(
   input  cell_attr_t attr,
   input  logic       pix_in,
   input  logic       blink_phase,
   input  logic       row_last,
   output logic       pix_out
);
   logic ul_eff;
   logic rev_eff;
   logic hide;
   logic d;

   always_comb begin
      ul_eff  = attr.underline;
      rev_eff = attr.reverse;
      hide    = 1'b0;
      if (attr.blink && blink_phase) begin
         if (attr.underline || attr.reverse) begin
            ul_eff  = 1'b0;
            rev_eff = 1'b0;
         end else begin
            hide = 1'b1;
         end
      end
      d = pix_in;
      if (ul_eff && row_last) d = 1'b1;
      if (rev_eff)            d = ~d;
      if (hide)               d = 1'b0;
      pix_out = d;
   end

endmodule

// File: rtl/bpc_pixel_combiner.sv
module bpc_pixel_combiner
   import bpc_pkg::*;
#(
   parameter int unsigned PLANES       = 8,
   parameter int unsigned PIX_PER_BYTE = 8,
   parameter int unsigned FG_PLANE     = 2,
   parameter int unsigned ATTR_PLANE   = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           load,
   input  logic                           pix_en,
   input  logic [PLANES*PIX_PER_BYTE-1:0] plane_data,
   input  logic [PLANES-1:0]              plane_enable,
   input  logic [PLANES-1:0]              plane_comp,
   input  logic                           attr_en,
   input  logic                           mode_640,
   input  logic                           mode_1280,
   input  logic                           half_phase,
   input  logic                           blink_phase,
   input  logic                           cell_row_last,
   output logic [PLANES-1:0]              pal_index,
   output logic                           fg_flag
);
   localparam int unsigned MSB_PLANE = PLANES - 1;
   localparam int unsigned NARROW    = PLANES / 2;
   localparam int unsigned W         = PIX_PER_BYTE;
   localparam int unsigned ATTR_BASE = ATTR_PLANE * W;

   generate
      if (PLANES < 4 || PLANES > 8) begin : g_bad_planes
         $error("bpc_pixel_combiner: PLANES must be 4 to 8");
      end
      if (PIX_PER_BYTE < 4) begin : g_bad_bytes
         $error("bpc_pixel_combiner: PIX_PER_BYTE must be at least 4");
      end
      if (FG_PLANE >= NARROW || ATTR_PLANE >= NARROW || FG_PLANE == ATTR_PLANE) begin : g_bad_roles
         $error("bpc_pixel_combiner: plane roles must be distinct lower planes");
      end
   endgenerate

   logic [PLANES-1:0] pix_bit;
   logic [PLANES-1:0] contrib;
   cell_attr_t        attr_in;
   cell_attr_t        attr_q;
   logic              fg_attr_bit;

   // Per-plane shifters
   generate
      for (genvar p = 0; p < PLANES; p++) begin : g_shift
         bpc_plane_shifter #(.WIDTH(W)) u_shift (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .shift (pix_en),
            .din   (plane_data[p*W +: W]),
            .pix   (pix_bit[p])
         );
      end
   endgenerate

   // Attribute capture from the attribute plane byte
   assign attr_in.underline = plane_data[ATTR_BASE + W - 1 - UL_FROM_TOP];
   assign attr_in.reverse   = plane_data[ATTR_BASE + W - 1 - REV_FROM_TOP];
   assign attr_in.blink     = plane_data[ATTR_BASE + W - 1 - BLK_FROM_TOP];

   bpc_attr_latch u_attr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .attr_in (attr_in),
      .attr_q  (attr_q)
   );

   bpc_attr_apply u_apply (
      .attr        (attr_q),
      .pix_in      (pix_bit[FG_PLANE]),
      .blink_phase (blink_phase),
      .row_last    (cell_row_last),
      .pix_out     (fg_attr_bit)
   );

   // Per-plane contribution; the role of each plane picks the variant
   generate
      for (genvar p = 0; p < PLANES; p++) begin : g_contrib
         if (p == ATTR_PLANE) begin : g_attr_plane
            always_comb begin
               if (attr_en || !plane_enable[p]) contrib[p] = plane_comp[p];
               else                             contrib[p] = pix_bit[p] ^ plane_comp[p];
            end
         end else if (p == FG_PLANE) begin : g_fg_plane
            logic d_fg;
            assign d_fg = attr_en ? fg_attr_bit : pix_bit[p];
            always_comb begin
               if (!plane_enable[p]) contrib[p] = plane_comp[p];
               else                  contrib[p] = d_fg ^ plane_comp[p];
            end
         end else if (p >= NARROW) begin : g_upper_plane
            always_comb begin
               if (!plane_enable[p] || mode_640) contrib[p] = plane_comp[p];
               else                              contrib[p] = pix_bit[p] ^ plane_comp[p];
            end
         end else begin : g_lower_plane
            always_comb begin
               if (!plane_enable[p]) contrib[p] = plane_comp[p];
               else                  contrib[p] = pix_bit[p] ^ plane_comp[p];
            end
         end
      end
   endgenerate

   // Output index with the 1280-mode phase substitution on the top bit
   always_comb begin
      pal_index = contrib;
      if (mode_1280) pal_index[MSB_PLANE] = half_phase;
   end

   assign fg_flag = contrib[FG_PLANE];

   // R3: disabled planes show their complement bit
   generate
      for (genvar p = 0; p < PLANES; p++) begin : g_chk
         if (p != ATTR_PLANE && p != MSB_PLANE) begin : g_chk_forced
            a_r3_forced : assert property (@(posedge clk) disable iff (!rst_n)
               !plane_enable[p] |-> (pal_index[p] == plane_comp[p]));
         end
         if (p >= NARROW && p != MSB_PLANE) begin : g_chk_narrow
            a_r5_narrow : assert property (@(posedge clk) disable iff (!rst_n)
               mode_640 |-> (pal_index[p] == plane_comp[p]));
         end
      end
   endgenerate

   // R6: top bit follows the phase in 1280 mode
   a_r6_phase : assert property (@(posedge clk) disable iff (!rst_n)
      mode_1280 |-> (pal_index[MSB_PLANE] == half_phase));

   // R11: attribute plane shows only its complement bit
   a_r11_attr_plane : assert property (@(posedge clk) disable iff (!rst_n)
      attr_en |-> (pal_index[ATTR_PLANE] == plane_comp[ATTR_PLANE]));

   // R10: blinking plain cell is hidden during the off phase
   a_r10_blink_hide : assert property (@(posedge clk) disable iff (!rst_n)
      (attr_en && blink_phase && attr_q.blink && !attr_q.reverse && !attr_q.underline
       && plane_enable[FG_PLANE]) |-> (fg_flag == plane_comp[FG_PLANE]));

endmodule

// File: tb/sim_bpc_pixel_combiner.sv
module sim_bpc_pixel_combiner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic        pix_en = 1'b0;
   logic [63:0] plane_data = '0;
   logic [7:0]  plane_enable = '0;
   logic [7:0]  plane_comp = '0;
   logic        attr_en = 1'b0;
   logic        mode_640 = 1'b0;
   logic        mode_1280 = 1'b0;
   logic        half_phase = 1'b0;
   logic        blink_phase = 1'b0;
   logic        cell_row_last = 1'b0;
   logic [7:0]  pal_index;
   logic        fg_flag;

   int checks = 0;
   int errors = 0;
   logic [31:0] lfsr = 32'h1ACE_B00C;

   always #10 clk = ~clk;

   bpc_pixel_combiner u0 (
      .clk(clk), .rst_n(rst_n), .load(load), .pix_en(pix_en),
      .plane_data(plane_data), .plane_enable(plane_enable), .plane_comp(plane_comp),
      .attr_en(attr_en), .mode_640(mode_640), .mode_1280(mode_1280),
      .half_phase(half_phase), .blink_phase(blink_phase), .cell_row_last(cell_row_last),
      .pal_index(pal_index), .fg_flag(fg_flag)
   );

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      logic [31:0] x = s;
      x ^= x << 13;
      x ^= x >> 17;
      x ^= x << 5;
      return x;
   endfunction

   // Bench model built from the requirements
   function automatic logic [7:0] model(input logic [63:0] b, input int pos,
                                        input logic [7:0] en, input logic [7:0] cp,
                                        input logic [5:0] m);
      logic m640 = m[0], m1280 = m[1], at = m[2], blk = m[3], row = m[4], ph = m[5];
      logic ul = b[31], rv = b[29], bl = b[28];
      logic [7:0] v;
      for (int i = 0; i < 8; i++) begin
         logic d = b[i*8 + 7 - pos];
         if (i == 2 && at) begin
            logic u = ul, r = rv, hide = 1'b0;
            if (bl && blk) begin
               if (u || r) begin u = 1'b0; r = 1'b0; end
               else hide = 1'b1;
            end
            if (u && row) d = 1'b1;
            if (r) d = ~d;
            if (hide) d = 1'b0;
         end
         if (i == 3 && at)                 v[i] = cp[i];
         else if (!en[i] || (m640 && i >= 4)) v[i] = cp[i];
         else                              v[i] = d ^ cp[i];
      end
      if (m1280) v[7] = ph;
      return v;
   endfunction

   function automatic string tag_for(input logic [7:0] diff, input logic [5:0] m);
      if (diff[7] && m[1])          return "R6";
      if ((|diff[7:4]) && m[0])      return "R5";
      if (diff[3] && m[2])          return "R11";
      if (diff[2] && m[2])          return "R7/R8/R9/R10 attribute";
      return "R2/R3/R4 plane";
   endfunction

   task automatic apply_modes(input logic [5:0] m);
      mode_640 = m[0]; mode_1280 = m[1]; attr_en = m[2];
      blink_phase = m[3]; cell_row_last = m[4]; half_phase = m[5];
   endtask

   task automatic check_one(input logic [63:0] b, input int pos, input logic [5:0] m,
                            input string ctx);
      logic [7:0] exp;
      apply_modes(m);
      #1;
      exp = model(b, pos, plane_enable, plane_comp, m);
      checks++;
      if (pal_index !== exp) begin
         errors++;
         $display("FAIL %s %s: pal_index=%h expected=%h pos=%0d modes=%b en=%h comp=%h",
                  tag_for(pal_index ^ exp, m), ctx, pal_index, exp, pos, m, plane_enable, plane_comp);
      end
      checks++;
      if (fg_flag !== exp[2]) begin
         errors++;
         $display("FAIL R12 %s: fg_flag=%b expected=%b pos=%0d modes=%b", ctx, fg_flag, exp[2], pos, m);
      end
   endtask

   task automatic do_load(input logic [63:0] b);
      @(negedge clk);
      plane_data = b;
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic step_pixel();
      @(negedge clk);
      pix_en = 1'b1;
      @(negedge clk);
      pix_en = 1'b0;
   endtask

   initial begin
      #5_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] en_set [4];
      logic [7:0] cp_set [4];
      logic [63:0] b;
      en_set[0] = 8'hFF; en_set[1] = 8'h00; en_set[2] = 8'h0F; en_set[3] = 8'hA5;
      cp_set[0] = 8'h00; cp_set[1] = 8'hFF; cp_set[2] = 8'h3C; cp_set[3] = 8'h81;

      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      plane_enable = 8'hFF; plane_comp = 8'h00;
      check_one(64'h0, 0, 6'b000000, "R1 reset all enabled");
      plane_enable = 8'h00; plane_comp = 8'h5A;
      check_one(64'h0, 0, 6'b000000, "R1 reset all forced");
      plane_enable = 8'hFF; plane_comp = 8'h00;
      check_one(64'h0, 0, 6'b000100, "R1 reset attributes clear");

      // Sweep: every plane 3 attribute nibble, mask pairs, pixels and mode combinations
      for (int pat = 0; pat < 16; pat++) begin
         for (int e = 0; e < 4; e++) begin
            for (int c = 0; c < 4; c++) begin
               lfsr = next_rand(lfsr);
               b[31:0] = lfsr;
               lfsr = next_rand(lfsr);
               b[63:32] = lfsr;
               b[31:28] = pat[3:0];   // R7 attribute nibble, R13-style highlight bit 6 swept too
               plane_enable = en_set[e];
               plane_comp = cp_set[c];
               apply_modes(6'b000000);
               do_load(b);
               for (int pos = 0; pos < 8; pos++) begin
                  for (int m = 0; m < 64; m++) begin
                     check_one(b, pos, m[5:0], "sweep");
                  end
                  if (pos < 7) step_pixel();
               end
            end
         end
      end

      // R2: load in the same cycle as a pixel step wins
      plane_enable = 8'hFF; plane_comp = 8'h00;
      apply_modes(6'b000000);
      do_load(64'h0F0F_0F0F_0F0F_0F0F);
      step_pixel();
      step_pixel();
      @(negedge clk);
      plane_data = 64'h80FF_00AA_55C3_3C81;
      load = 1'b1;
      pix_en = 1'b1;
      @(negedge clk);
      load = 1'b0;
      pix_en = 1'b0;
      check_one(64'h80FF_00AA_55C3_3C81, 0, 6'b000000, "R2 load priority");

      // R8/R9/R10: targeted attribute cases, plane 2 data all zero
      plane_enable = 8'h04; plane_comp = 8'h00;
      do_load(64'h0000_0000_8000_0000);           // underline only
      check_one(64'h0000_0000_8000_0000, 0, 6'b010100, "R8 underline forced");
      do_load(64'h0000_0000_A000_0000);           // underline + reverse
      check_one(64'h0000_0000_A000_0000, 0, 6'b010100, "R9 reversed underline");
      do_load(64'h0000_0000_10FF_0000);           // blink only, plane 2 ones
      check_one(64'h0000_0000_10FF_0000, 0, 6'b001100, "R10 blink hides");
      check_one(64'h0000_0000_10FF_0000, 0, 6'b000100, "R10 blink on phase");
      do_load(64'h0000_0000_7000_0000);           // blink + reverse + highlight
      check_one(64'h0000_0000_7000_0000, 0, 6'b001100, "R10 blink suppresses reverse");
      check_one(64'h0000_0000_7000_0000, 0, 6'b000100, "R9 reverse with highlight ignored");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule